// File: doc/BRIEF.md
# Dual-LUT Configurable Logic Block

This block is one programmable logic cell of a fine-grained gate array. It holds two 4-input look-up tables. Each table takes its four inputs from an 8-track wiring channel, and a 3-bit select field per input picks the track. Each table output feeds its own flip-flop. A mode bit per output chooses whether the cell presents the table value directly or the value the flip-flop captured on the last rising clock edge. Each output is then driven onto the wiring channel on the far side through a tri-state driver. The driver is modelled here as a value plus an enable.

The cell holds no configuration storage. Its whole behaviour comes from a flat configuration vector that is applied in parallel, so a new vector takes effect at once, for every table bit, selector and enable. Each table has a 30-bit slice: table 0 at bits 29:0 and table 1 at bits 59:30. Within a slice, bits 15:0 hold the truth table, bits 18:16, 21:19, 24:22 and 27:25 hold the track selects for inputs 0 to 3, bit 28 is the output mode and bit 29 is the driver enable.

Top module: `dual_lut_cell`

## Requirements
- R1: While `rst` is high on a rising edge, both flip-flops are cleared to 0. With the mode bit at 1, the driver enable at 1 and reset applied, `out_val` reads 0 until the first edge after reset is released.
- R2: With the mode bit at 0 (combinational), an output equals truth bit `{in3,in2,in1,in0}` of its slice in the same cycle, with input 0 as the least significant address bit.
- R3: Input n of a table carries channel track `chan_in[s]`, where s is the 3-bit select field of that input (slice bits 16+3n to 18+3n).
- R4: With the mode bit at 1 (registered), an output equals the table value sampled at the most recent rising edge, and a change of inputs between edges does not reach it.
- R5: With the driver-enable bit at 0, `out_en` for that output is 0 and `out_val` is 0, whatever the table and mode say. With the bit at 1, `out_en` is 1.
- R6: The two tables act independently. Table 0 uses only slice bits 29:0 and drives index 0 of the outputs; table 1 uses only bits 59:30 and drives index 1.
- R7: Each flip-flop captures its table value on every rising edge outside reset, whatever the mode. Switching an output from combinational to registered therefore shows the value captured at the last edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both flip-flops, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chan_in | input | 8 | Input-side wiring channel tracks |
| cfg | input | 60 | Flat configuration vector, two 30-bit slices |
| out_val | output | 2 | Driven data per output, 0 when not driven |
| out_en | output | 2 | Driver enable per output |

## Verification
Two events can meet in one cycle: a change of the output mode and a change of the table inputs. The bench provokes this by capturing one input pattern on an edge while in combinational mode. Between edges it then applies a second pattern, with the opposite table value, together with a switch to registered mode. The output is judged correct only if it shows the first pattern's value until the next edge and the second pattern's value after it. A reset asserted while a flip-flop holds 1 is checked in the same way.

// File: rtl/clb_pkg.sv
package clb_pkg;
   localparam int DEF_TRACKS   = 8;
   localparam int DEF_LUT_K    = 4;
   localparam int DEF_NUM_LUTS = 2;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;
endpackage

// File: rtl/clb_track_mux.sv
module clb_track_mux #(
   parameter int TRACKS = 8,
   parameter int SEL_W  = 3
) (
   input  logic [TRACKS-1:0] chan,
   input  logic [SEL_W-1:0]  sel,
   output logic              pick
);
   generate
      if ((1 << SEL_W) == TRACKS) begin : g_full
         assign pick = chan[sel];
      end else begin : g_partial
         always_comb begin
            pick = 1'b0;
            for (int t = 0; t < TRACKS; t++) begin
               if (sel == SEL_W'(t)) pick = chan[t];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
   parameter int K = 4
) (
   input  logic [(1<<K)-1:0] truth,
   input  logic [K-1:0]      addr,
   output logic              y
);
   assign y = truth[addr];
endmodule

// File: rtl/clb_out_stage.sv
module clb_out_stage
   import clb_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      d,
   input  out_mode_e mode,
   input  logic      oe,
   output logic      val,
   output logic      en
);
   logic ff_q;
   logic sel_v;
   logic seen_run;

   always_ff @(posedge clk) begin
      if (rst) ff_q <= 1'b0;
      else     ff_q <= d;
   end

   always_ff @(posedge clk) seen_run <= !rst;

   assign sel_v = (mode == OUT_REG) ? ff_q : d;
   assign val   = oe & sel_v;
   assign en    = oe;

   // R1
   rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!seen_run) |-> (ff_q == 1'b0));

   // R4
   reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_run && mode == OUT_REG && oe) |-> (val == $past(d)));
endmodule

// File: rtl/dual_lut_cell.sv
module dual_lut_cell
   import clb_pkg::*;
#(
   parameter int TRACKS   = DEF_TRACKS,
   parameter int LUT_K    = DEF_LUT_K,
   parameter int NUM_LUTS = DEF_NUM_LUTS,
   localparam int SEL_W    = $clog2(TRACKS),
   localparam int TRUTH_W  = 1 << LUT_K,
   localparam int MODE_BIT = TRUTH_W + LUT_K*SEL_W,
   localparam int OE_BIT   = MODE_BIT + 1,
   localparam int SLICE_W  = OE_BIT + 1,
   localparam int CFG_W    = NUM_LUTS * SLICE_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [TRACKS-1:0]   chan_in,
   input  logic [CFG_W-1:0]    cfg,
   output logic [NUM_LUTS-1:0] out_val,
   output logic [NUM_LUTS-1:0] out_en
);
   generate
      if (TRACKS < 2)   begin : g_bad_tracks $error("TRACKS must be at least 2"); end
      if (LUT_K < 1 || LUT_K > 6) begin : g_bad_k $error("LUT_K out of range 1..6"); end
      if (NUM_LUTS < 1) begin : g_bad_n $error("NUM_LUTS must be at least 1"); end
   endgenerate

   generate
      for (genvar c = 0; c < NUM_LUTS; c++) begin : g_cell
         logic [SLICE_W-1:0] slice;
         logic [LUT_K-1:0]   addr;
         logic               lut_y;
         out_mode_e          mode;

         assign slice = cfg[c*SLICE_W +: SLICE_W];
         assign mode  = out_mode_e'(slice[MODE_BIT]);

         for (genvar n = 0; n < LUT_K; n++) begin : g_in
            clb_track_mux #(.TRACKS(TRACKS), .SEL_W(SEL_W)) u_mux (
               .chan (chan_in),
               .sel  (slice[TRUTH_W + n*SEL_W +: SEL_W]),
               .pick (addr[n])
            );
         end

         clb_lut #(.K(LUT_K)) u_lut (
            .truth (slice[TRUTH_W-1:0]),
            .addr  (addr),
            .y     (lut_y)
         );

         clb_out_stage u_out (
            .clk  (clk),
            .rst  (rst),
            .d    (lut_y),
            .mode (mode),
            .oe   (slice[OE_BIT]),
            .val  (out_val[c]),
            .en   (out_en[c])
         );

         // R5
         dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (!cfg[c*SLICE_W + OE_BIT]) |-> (!out_en[c] && !out_val[c]));

         // R2
         const_one_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg[c*SLICE_W +: TRUTH_W] == '1 && !cfg[c*SLICE_W + MODE_BIT]
             && cfg[c*SLICE_W + OE_BIT]) |-> out_val[c]);

         // R2
         const_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg[c*SLICE_W +: TRUTH_W] == '0 && !cfg[c*SLICE_W + MODE_BIT])
            |-> !out_val[c]);
      end
   endgenerate
endmodule

// File: tb/dual_lut_cell_test.sv
`timescale 1ns/1ps
module dual_lut_cell_test;
   logic        clk = 1'b0;
   logic        rst;
   logic [7:0]  chan_in;
   logic [59:0] cfg;
   logic [1:0]  out_val;
   logic [1:0]  out_en;

   int n_chk = 0;
   int n_bad = 0;

   dual_lut_cell uut (
      .clk(clk), .rst(rst), .chan_in(chan_in), .cfg(cfg),
      .out_val(out_val), .out_en(out_en)
   );

   always #2.5 clk = ~clk;

   function automatic logic [29:0] mk(input logic [15:0] t,
      input logic [2:0] s0, input logic [2:0] s1, input logic [2:0] s2,
      input logic [2:0] s3, input logic m, input logic o);
      return {o, m, s3, s2, s1, s0, t};
   endfunction

   function automatic logic fx(input logic [15:0] t,
      input logic [2:0] s0, input logic [2:0] s1, input logic [2:0] s2,
      input logic [2:0] s3, input logic [7:0] ch);
      return t[{ch[s3], ch[s2], ch[s1], ch[s0]}];
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      chan_in = 8'hFF;
      cfg = {mk(16'hFFFF,0,1,2,3,1,1), mk(16'hFFFF,0,1,2,3,1,1)};
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      check("R1 out0 in reset", out_val[0], 1'b0);
      check("R1 out1 in reset", out_val[1], 1'b0);
      rst = 1'b0;
      #0.5;
      check("R1 out0 after release before edge", out_val[0], 1'b0);
      @(posedge clk); #1;
      check("R1 out0 after first edge", out_val[0], 1'b1);
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      check("R1 mid-run reset clears", out_val[0], 1'b0);
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_addr();
      logic [15:0] t = 16'hA5C3;
      @(negedge clk);
      cfg = {mk(16'h0000,0,1,2,3,0,1), mk(t,0,1,2,3,0,1)};
      for (int v = 0; v < 16; v++) begin
         chan_in = 8'(v) | 8'hF0;
         #1;
         check("R2 truth addressing", out_val[0], t[v]);
         check("R5 enable high", out_en[0], 1'b1);
      end
   endtask

   task automatic t_select();
      logic [15:0] t = 16'h1E69;
      logic [7:0] pats [6] = '{8'h80, 8'h24, 8'h64, 8'hA5, 8'h5A, 8'hE1};
      @(negedge clk);
      cfg = {mk(16'h0000,0,1,2,3,0,1), mk(t,7,5,2,6,0,1)};
      foreach (pats[i]) begin
         chan_in = pats[i];
         #1;
         check("R3 track select", out_val[0], fx(t,7,5,2,6,pats[i]));
      end
   endtask

   task automatic t_registered();
      logic [15:0] t = 16'h8000;
      @(negedge clk);
      cfg = {mk(16'h0000,0,1,2,3,0,1), mk(t,4,5,6,7,1,1)};
      chan_in = 8'hF0;
      @(posedge clk); #1;
      check("R4 captured one", out_val[0], 1'b1);
      @(negedge clk); chan_in = 8'h70; #1;
      check("R4 holds between edges", out_val[0], 1'b1);
      @(posedge clk); #1;
      check("R4 captured zero", out_val[0], 1'b0);
   endtask

   task automatic t_tristate();
      @(negedge clk);
      chan_in = 8'h00;
      cfg = {mk(16'hFFFF,0,1,2,3,1,0), mk(16'hFFFF,0,1,2,3,0,0)};
      @(posedge clk); #1;
      check("R5 comb disabled val", out_val[0], 1'b0);
      check("R5 comb disabled en", out_en[0], 1'b0);
      check("R5 reg disabled val", out_val[1], 1'b0);
      check("R5 reg disabled en", out_en[1], 1'b0);
   endtask

   task automatic t_indep();
      logic [7:0] pats [4] = '{8'h0F, 8'h1F, 8'hE7, 8'h30};
      @(negedge clk);
      cfg = {mk(16'h6996,4,5,6,7,0,1), mk(16'h8000,0,1,2,3,0,1)};
      foreach (pats[i]) begin
         chan_in = pats[i];
         #1;
         check("R6 table0 AND", out_val[0], &pats[i][3:0]);
         check("R6 table1 XOR", out_val[1], ^pats[i][7:4]);
      end
      cfg[29:0] = mk(16'h0000,0,1,2,3,0,1);
      chan_in = 8'h10; #1;
      check("R6 table1 unaffected by slice0", out_val[1], 1'b1);
      check("R6 table0 follows slice0", out_val[0], 1'b0);
   endtask

   task automatic t_mode_switch();
      logic [15:0] t = 16'h0002;
      @(negedge clk);
      cfg = {mk(16'h0000,0,1,2,3,0,1), mk(t,0,1,2,3,0,1)};
      chan_in = 8'h01;
      #1;
      check("R7 comb before switch", out_val[0], 1'b1);
      @(posedge clk);
      @(negedge clk);
      chan_in = 8'h02;
      cfg[28] = 1'b1;
      #1;
      check("R7 switch shows last capture", out_val[0], 1'b1);
      @(posedge clk); #1;
      check("R7 next edge shows new value", out_val[0], 1'b0);
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_addr();
      t_select();
      t_registered();
      t_tristate();
      t_indep();
      t_mode_switch();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule